// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block is the per-processor half of a two-level interrupt controller. A source layer offers it interrupts, each tagged with a 24-bit source number and an 8-bit priority. The block keeps a single pending slot and drives one interrupt line to its processor. In every priority comparison the numerically lower value wins, and 0xFF means "none". When an offer loses against the slot, or is pushed out of it by a stronger one, the block hands that source back to the source layer as a reject pulse. The source layer can offer it again later.

Software reaches the block through five register operations, each a single-cycle command with a 32-bit data word. The presentation word places the processor priority in bits 31:24 and the pending source in bits 23:0. An inter-processor interrupt is modelled as a separate priority byte. When that priority beats the processor priority, the inter-processor interrupt takes the same pending slot under a reserved source number. End-of-interrupt and priority changes can open the slot again. When that happens the block sends a resend pulse, asking the source layer to replay what it rejected earlier.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset the presentation word reads 0, the pending priority and the IPI priority are 0xFF, `irqOut` is low and no reject, EOI, resend or read pulse is driven.
- R2: A request whose priority is not below the processor priority is rejected: `rejValid` pulses on the next cycle with the request's source, and the pending slot is unchanged.
- R3: A request is also rejected, leaving the slot unchanged, when a source is pending whose priority value is not greater than the request's.
- R4: Any other request takes the slot with its source and priority and raises `irqOut`. A source it displaces is rejected on the next cycle. Only one of `reqValid` and `opValid` is asserted in any cycle.
- R5: Accept (opcode 0) returns the old presentation word on `rdData`, with `rdValid` set, on the next cycle. It lowers `irqOut`, loads the old pending priority into the processor priority, clears the source field and sets the pending priority to 0xFF.
- R6: Poll (opcode 1) returns the presentation word on `rdData` and the IPI priority on `rdIpi`, and changes no state.
- R7: Set IPI priority (opcode 2 is EOI; opcode 4 is this one, value in data bits 7:0) with a value below the processor priority installs source `IPI_SRC` (default 2) at that priority and raises `irqOut`, unless the pending priority value is not greater than the new value. Any displaced source is rejected.
- R8: Set IPI priority with a value not below the processor priority only stores the value.
- R9: Set processor priority (opcode 3, value in data bits 7:0) to a lower value, while a source is pending at a priority value not below the new one, clears the slot, rejects that source, sets the pending priority to 0xFF and lowers `irqOut`.
- R10: Set processor priority to an equal or higher value with nothing pending pulses `resendReq`. If the IPI priority is below the new processor priority, it also installs the IPI source.
- R11: EOI (opcode 2) loads the processor priority from data bits 31:24 and pulses `eoiValid` with data bits 23:0. If nothing is pending it also performs the resend of R10 against the new priority.
- R12: Opcodes 5 to 7 have no effect on state or outputs.
- R13: `irqOut` is high exactly when the source field of the presentation word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Source layer offers an interrupt this cycle |
| reqSrc | input | 24 | Source number of the offer (non-zero) |
| reqPrio | input | 8 | Priority of the offer |
| opValid | input | 1 | Register operation this cycle |
| opCode | input | 3 | Operation: 0 accept, 1 poll, 2 EOI, 3 set processor priority, 4 set IPI priority |
| opData | input | 32 | Operation data word |
| irqOut | output | 1 | Interrupt line to the processor |
| rdValid | output | 1 | Pulse: `rdData` and `rdIpi` hold an accept or poll result |
| rdData | output | 32 | Presentation word returned by accept or poll |
| rdIpi | output | 8 | IPI priority returned with the read |
| rejValid | output | 1 | Pulse: source handed back to the source layer |
| rejSrc | output | 24 | Rejected source number |
| eoiValid | output | 1 | Pulse: end-of-interrupt forwarded to the source layer |
| eoiSrc | output | 24 | Source number of the end-of-interrupt |
| resendReq | output | 1 | Pulse: source layer should replay its rejected sources |

## Verification
The assertions assume that the source layer never offers an interrupt in a cycle that carries a register operation, and that every offered source number is non-zero. The stimulus keeps to both rules: each step drives only an offer or only an operation, and it uses source numbers of 100 and above. The IPI source number does not appear among these offered sources, so every reject can be traced to its cause without ambiguity.

// File: rtl/presenter_pkg.sv
package presenter_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;

  localparam logic [2:0] OP_ACCEPT  = 3'd0;
  localparam logic [2:0] OP_POLL    = 3'd1;
  localparam logic [2:0] OP_EOI     = 3'd2;
  localparam logic [2:0] OP_SET_CPU = 3'd3;
  localparam logic [2:0] OP_SET_IPI = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic              setCppr;
    logic [PRIO_W-1:0] cpprVal;
    logic              setMfrr;
    logic [PRIO_W-1:0] mfrrVal;
    logic              install;
    logic [SRC_W-1:0]  instSrc;
    logic [PRIO_W-1:0] instPrio;
    logic              clearPend;
    logic              acceptLd;
    logic              capture;
    logic              rejFire;
    logic [SRC_W-1:0]  rejSrc;
    logic              eoiFire;
    logic [SRC_W-1:0]  eoiSrc;
    logic              resendFire;
  } ctlStrobes_t;
endpackage

// File: rtl/presenter_ctl.sv
module presenter_ctl
  import presenter_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [WORD_W-1:0] opData,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [PRIO_W-1:0] cpprQ,
  input  logic [SRC_W-1:0]  xisrQ,
  input  logic [PRIO_W-1:0] pendQ,
  input  logic [PRIO_W-1:0] mfrrQ,
  output ctlStrobes_t       stb
);
  logic              busy;
  logic [PRIO_W-1:0] lowPrio;
  logic [PRIO_W-1:0] topPrio;
  logic [SRC_W-1:0]  lowSrc;

  assign busy    = (xisrQ != '0);
  assign lowPrio = opData[PRIO_W-1:0];
  assign topPrio = opData[WORD_W-1:SRC_W];
  assign lowSrc  = opData[SRC_W-1:0];

  always_comb begin
    stb = '0;
    if (opValid) begin
      case (opCode)
        OP_ACCEPT: begin
          stb.capture  = 1'b1;
          stb.acceptLd = 1'b1;
        end
        OP_POLL: stb.capture = 1'b1;
        OP_SET_IPI: begin
          stb.setMfrr = 1'b1;
          stb.mfrrVal = lowPrio;
          if (lowPrio < cpprQ && !(busy && pendQ <= lowPrio)) begin
            stb.rejFire  = busy;
            stb.rejSrc   = xisrQ;
            stb.install  = 1'b1;
            stb.instSrc  = IPI_SRC;
            stb.instPrio = lowPrio;
          end
        end
        OP_SET_CPU: begin
          stb.setCppr = 1'b1;
          stb.cpprVal = lowPrio;
          if (lowPrio < cpprQ) begin
            if (busy && lowPrio <= pendQ) begin
              stb.clearPend = 1'b1;
              stb.rejFire   = 1'b1;
              stb.rejSrc    = xisrQ;
            end
          end else if (!busy) begin
            stb.resendFire = 1'b1;
            if (mfrrQ < lowPrio) begin
              stb.install  = 1'b1;
              stb.instSrc  = IPI_SRC;
              stb.instPrio = mfrrQ;
            end
          end
        end
        OP_EOI: begin
          stb.setCppr = 1'b1;
          stb.cpprVal = topPrio;
          stb.eoiFire = 1'b1;
          stb.eoiSrc  = lowSrc;
          if (!busy) begin
            stb.resendFire = 1'b1;
            if (mfrrQ < topPrio) begin
              stb.install  = 1'b1;
              stb.instSrc  = IPI_SRC;
              stb.instPrio = mfrrQ;
            end
          end
        end
        default: stb = '0;
      endcase
    end else if (reqValid) begin
      if (reqPrio >= cpprQ || (busy && pendQ <= reqPrio)) begin
        stb.rejFire = 1'b1;
        stb.rejSrc  = reqSrc;
      end else begin
        stb.rejFire  = busy;
        stb.rejSrc   = xisrQ;
        stb.install  = 1'b1;
        stb.instSrc  = reqSrc;
        stb.instPrio = reqPrio;
      end
    end
  end
endmodule

// File: rtl/presenter_dp.sv
module presenter_dp
  import presenter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  output logic [PRIO_W-1:0] cpprQ,
  output logic [SRC_W-1:0]  xisrQ,
  output logic [PRIO_W-1:0] pendQ,
  output logic [PRIO_W-1:0] mfrrQ,
  output logic              irqOut,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic [PRIO_W-1:0] rdIpi,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendReq
);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  // presentation state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpprQ  <= '0;
      xisrQ  <= '0;
      pendQ  <= PRIO_NONE;
      mfrrQ  <= PRIO_NONE;
      irqOut <= 1'b0;
    end else begin
      if (stb.setMfrr) mfrrQ <= stb.mfrrVal;
      if (stb.acceptLd) begin
        cpprQ  <= pendQ;
        xisrQ  <= '0;
        pendQ  <= PRIO_NONE;
        irqOut <= 1'b0;
      end else begin
        if (stb.setCppr) cpprQ <= stb.cpprVal;
        if (stb.clearPend) begin
          xisrQ  <= '0;
          pendQ  <= PRIO_NONE;
          irqOut <= 1'b0;
        end else if (stb.install) begin
          xisrQ  <= stb.instSrc;
          pendQ  <= stb.instPrio;
          irqOut <= 1'b1;
        end
      end
    end
  end

  // replies to software and the source layer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdData    <= '0;
      rdIpi     <= PRIO_NONE;
      rejValid  <= 1'b0;
      rejSrc    <= '0;
      eoiValid  <= 1'b0;
      eoiSrc    <= '0;
      resendReq <= 1'b0;
    end else begin
      rdValid   <= stb.capture;
      rejValid  <= stb.rejFire;
      eoiValid  <= stb.eoiFire;
      resendReq <= stb.resendFire;
      if (stb.capture) begin
        rdData <= {cpprQ, xisrQ};
        rdIpi  <= mfrrQ;
      end
      if (stb.rejFire) rejSrc <= stb.rejSrc;
      if (stb.eoiFire) eoiSrc <= stb.eoiSrc;
    end
  end
endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
  import presenter_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [WORD_W-1:0] opData,
  output logic              irqOut,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic [PRIO_W-1:0] rdIpi,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendReq
);
  ctlStrobes_t       stb;
  logic [PRIO_W-1:0] cpprQ;
  logic [SRC_W-1:0]  xisrQ;
  logic [PRIO_W-1:0] pendQ;
  logic [PRIO_W-1:0] mfrrQ;

  presenter_ctl #(.IPI_SRC(IPI_SRC)) ctl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .opData  (opData),
    .reqValid(reqValid),
    .reqSrc  (reqSrc),
    .reqPrio (reqPrio),
    .cpprQ   (cpprQ),
    .xisrQ   (xisrQ),
    .pendQ   (pendQ),
    .mfrrQ   (mfrrQ),
    .stb     (stb)
  );

  presenter_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cpprQ    (cpprQ),
    .xisrQ    (xisrQ),
    .pendQ    (pendQ),
    .mfrrQ    (mfrrQ),
    .irqOut   (irqOut),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rdIpi    (rdIpi),
    .rejValid (rejValid),
    .rejSrc   (rejSrc),
    .eoiValid (eoiValid),
    .eoiSrc   (eoiSrc),
    .resendReq(resendReq)
  );
endmodule

// File: rtl/presenter_chk.sv
module presenter_chk
  import presenter_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [SRC_W-1:0]  reqSrc,
  input logic [PRIO_W-1:0] reqPrio,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [WORD_W-1:0] opData,
  input logic              irqOut,
  input logic              rdValid,
  input logic [WORD_W-1:0] rdData,
  input logic [PRIO_W-1:0] rdIpi,
  input logic              rejValid,
  input logic [SRC_W-1:0]  rejSrc,
  input logic              eoiValid,
  input logic [SRC_W-1:0]  eoiSrc,
  input logic [PRIO_W-1:0] cpprQ,
  input logic [SRC_W-1:0]  xisrQ,
  input logic [PRIO_W-1:0] pendQ,
  input logic [PRIO_W-1:0] mfrrQ
);
  AST_REQ_OP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && opValid)); // R4

  AST_IRQ_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (xisrQ != '0)); // R13

  AST_REQ_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !opValid && reqPrio >= cpprQ)
    |=> (rejValid && rejSrc == $past(reqSrc) && $stable(xisrQ))); // R2

  AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !opValid && reqPrio < cpprQ && (xisrQ == '0 || pendQ > reqPrio))
    |=> (irqOut && xisrQ == $past(reqSrc) && pendQ == $past(reqPrio))); // R4

  AST_ACCEPT_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ACCEPT)
    |=> (!irqOut && xisrQ == '0 && pendQ == '1 && rdValid
         && rdData == {$past(cpprQ), $past(xisrQ)})); // R5

  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_POLL)
    |=> ($stable(cpprQ) && $stable(xisrQ) && $stable(pendQ) && $stable(mfrrQ)
         && rdValid && rdIpi == mfrrQ)); // R6

  AST_EOI_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_EOI)
    |=> (eoiValid && eoiSrc == $past(opData[SRC_W-1:0])
         && cpprQ == $past(opData[WORD_W-1:SRC_W]))); // R11
endmodule

bind cpu_irq_presenter presenter_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqSrc  (reqSrc),
  .reqPrio (reqPrio),
  .opValid (opValid),
  .opCode  (opCode),
  .opData  (opData),
  .irqOut  (irqOut),
  .rdValid (rdValid),
  .rdData  (rdData),
  .rdIpi   (rdIpi),
  .rejValid(rejValid),
  .rejSrc  (rejSrc),
  .eoiValid(eoiValid),
  .eoiSrc  (eoiSrc),
  .cpprQ   (cpprQ),
  .xisrQ   (xisrQ),
  .pendQ   (pendQ),
  .mfrrQ   (mfrrQ)
);

// File: tb/cpu_irq_presenter_tb.sv
`timescale 1ns/1ps
module cpu_irq_presenter_tb_top;
  localparam logic [23:0] IPI = 24'd2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqSrc = '0;
  logic [7:0]  reqPrio = '0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] opData = '0;
  logic        irqOut, rdValid, rejValid, eoiValid, resendReq;
  logic [31:0] rdData;
  logic [7:0]  rdIpi;
  logic [23:0] rejSrc, eoiSrc;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_irq_presenter #(.IPI_SRC(IPI)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSrc(reqSrc), .reqPrio(reqPrio),
    .opValid(opValid), .opCode(opCode), .opData(opData), .irqOut(irqOut),
    .rdValid(rdValid), .rdData(rdData), .rdIpi(rdIpi), .rejValid(rejValid),
    .rejSrc(rejSrc), .eoiValid(eoiValid), .eoiSrc(eoiSrc), .resendReq(resendReq)
  );

  // reference state derived from the requirements
  logic [7:0]  mCp, mPend, mMfrr;
  logic [23:0] mSrc;
  logic        eRej, eEoi, eRes, eRdV;
  logic [23:0] eRejSrc, eEoiSrc;
  logic [31:0] eRdD;
  logic [7:0]  eRdI;
  string       tag;

  task automatic takeSlot(input logic [23:0] s, input logic [7:0] p);
    if (mSrc != 0) begin eRej = 1'b1; eRejSrc = mSrc; end
    mSrc = s; mPend = p;
  endtask

  task automatic reopen(input logic [7:0] newCp);
    eRes = 1'b1;
    if (mMfrr < newCp) takeSlot(IPI, mMfrr);
  endtask

  task automatic check(input bit ok, input string t, input string act, input string exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%s expected=%s", t, act, exp);
    end
  endtask

  task automatic applyStep(input bit isOp, input logic [2:0] code, input logic [31:0] data,
                           input logic [23:0] src, input logic [7:0] prio);
    logic [7:0] lo;
    logic [7:0] hi;
    bit ok;
    lo = data[7:0];
    hi = data[31:24];
    eRej = 0; eEoi = 0; eRes = 0; eRdV = 0;
    eRejSrc = 0; eEoiSrc = 0; eRdD = 0; eRdI = 0;
    if (!isOp) begin
      if (prio >= mCp) begin tag = "R2"; eRej = 1; eRejSrc = src; end
      else if (mSrc != 0 && mPend <= prio) begin tag = "R3"; eRej = 1; eRejSrc = src; end
      else begin tag = "R4"; takeSlot(src, prio); end
    end else begin
      case (code)
        3'd0: begin
          tag = "R5"; eRdV = 1; eRdD = {mCp, mSrc}; eRdI = mMfrr;
          mCp = mPend; mSrc = 0; mPend = 8'hFF;
        end
        3'd1: begin tag = "R6"; eRdV = 1; eRdD = {mCp, mSrc}; eRdI = mMfrr; end
        3'd2: begin
          tag = "R11"; mCp = hi; eEoi = 1; eEoiSrc = data[23:0];
          if (mSrc == 0) reopen(hi);
        end
        3'd3: begin
          if (lo < mCp) begin
            tag = "R9";
            mCp = lo;
            if (mSrc != 0 && lo <= mPend) begin
              eRej = 1; eRejSrc = mSrc; mSrc = 0; mPend = 8'hFF;
            end
          end else begin
            tag = "R10";
            mCp = lo;
            if (mSrc == 0) reopen(lo);
          end
        end
        3'd4: begin
          mMfrr = lo;
          if (lo < mCp) begin
            tag = "R7";
            if (!(mSrc != 0 && mPend <= lo)) takeSlot(IPI, lo);
          end else tag = "R8";
        end
        default: tag = "R12";
      endcase
    end
    reqValid = !isOp; reqSrc = src; reqPrio = prio;
    opValid = isOp; opCode = code; opData = data;
    @(negedge clk);
    reqValid = 0; opValid = 0;
    ok = (rejValid == eRej) && (!eRej || rejSrc == eRejSrc)
      && (eoiValid == eEoi) && (!eEoi || eoiSrc == eEoiSrc)
      && (resendReq == eRes) && (rdValid == eRdV)
      && (!eRdV || (rdData == eRdD && rdIpi == eRdI));
    check(ok, tag,
      $sformatf("rej=%0b/%h eoi=%0b/%h res=%0b rd=%0b/%h/%h", rejValid, rejSrc,
                eoiValid, eoiSrc, resendReq, rdValid, rdData, rdIpi),
      $sformatf("rej=%0b/%h eoi=%0b/%h res=%0b rd=%0b/%h/%h", eRej, eRejSrc,
                eEoi, eEoiSrc, eRes, eRdV, eRdD, eRdI));
    // R13: line follows the source field
    check(irqOut == (mSrc != 0), "R13", $sformatf("irq=%0b", irqOut),
          $sformatf("irq=%0b", mSrc != 0));
  endtask

  task automatic doOp(input logic [2:0] code, input logic [31:0] data);
    applyStep(1'b1, code, data, 24'd0, 8'd0);
  endtask

  task automatic doReq(input logic [23:0] src, input logic [7:0] prio);
    applyStep(1'b0, 3'd0, 32'd0, src, prio);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    mCp = 8'h00; mSrc = 0; mPend = 8'hFF; mMfrr = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(!irqOut && !rejValid && !eoiValid && !resendReq && !rdValid, "R1",
          $sformatf("%0b%0b%0b%0b%0b", irqOut, rejValid, eoiValid, resendReq, rdValid), "00000");
    doOp(3'd1, 32'd0);
    check(rdData == 32'd0 && rdIpi == 8'hFF, "R1",
          $sformatf("%h/%h", rdData, rdIpi), "00000000/ff");
    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [7:0] cv;
          cv = (c == 3) ? 8'hFF : 8'(4 * (c + 1));
          doOp(3'd0, 32'd0);
          doOp(3'd2, {cv, 24'(a * 16 + b)});
          doOp(3'd4, 32'((a * 3 + b) & 15));
          doReq(24'(100 + a), 8'(a));
          doReq(24'(300 + b), 8'(b));
          doOp(3'd3, 32'(b));
          doOp(3'd1, 32'd0);
          doOp(3'(5 + (a % 3)), 32'hFFFF_FFFF);
          doOp(3'd1, 32'd0);
          doOp(3'd4, 32'h0000_00FF);
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule